// File: doc/BRIEF.md
# Bit scan and bit-test unit

This execution unit performs five single-bit operations on a 16-bit or 32-bit operand: a forward scan that finds the lowest set bit of a source word, and a family of bit-test operations that read one bit of a destination word into the carry flag and then either keep, invert, clear or set it. The bit position for the test family comes from an offset that is either an immediate byte or a register value. That offset is reduced modulo the operand width. The scan takes no offset at all.

A request is presented with `in_valid` together with the opcode, the size select, both operands and the offset. One cycle later the unit raises `out_valid` with the result word, a write-enable for the destination, and the carry and zero flags, each with its own update strobe. Between responses the strobes are low and the result and flag values hold. A small state machine has two states. `ST_IDLE` is entered from reset and whenever no request arrives. `ST_RESP` is entered on any cycle with `in_valid` high (transition *accept*) and left when `in_valid` is low (transition *drain*). Back-to-back requests keep the machine in `ST_RESP`.

Top module: `bitop_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `dst_we`, `cf_upd`, `zf_upd`, `cf`, `zf` and `result` are all zero.
- R2: A request with `in_valid` high produces `out_valid` high exactly one clock later. With no request, `out_valid`, `dst_we`, `cf_upd` and `zf_upd` are low, and `result`, `cf` and `zf` keep their previous values.
- R3: Scan (opcode 0) with a nonzero operand returns the index of the lowest set bit of `src`, zero-extended, with `dst_we`=1, `zf`=0, `zf_upd`=1 and `cf_upd`=0. For example, `src`=01241240h gives 6.
- R4: Scan with an all-zero operand sets `zf`=1 with `zf_upd`=1, keeps `dst_we`=0, and returns `dst` unchanged on `result`.
- R5: With `size32`=0 the scan looks only at `src[15:0]`. For example, `src`=00010000h counts as all-zero.
- R6: The scan ignores the offset inputs and applies no modulo.
- R7: For the test family the bit index is the offset modulo 32 (`size32`=1) or modulo 16 (`size32`=0). The offset is the zero-extended `imm_off` when `imm_sel`=1 and `reg_off` otherwise. For example, offset 33 on 32 bits selects bit 1.
- R8: Bit test (opcode 1) puts the selected bit of `dst` on `cf` with `cf_upd`=1, keeps `dst_we`=0 and `zf_upd`=0 (`zf` holds), and returns `dst` on `result`. For example, FFFF0080h at offset 2 gives `cf`=0, and 1234081Fh at offset 33 gives `cf`=1.
- R9: Opcodes 2, 3 and 4 put the old selected bit on `cf` with `cf_upd`=1 and `zf_upd`=0. They raise `dst_we` and return `dst` with that bit inverted (2), cleared (3) or set (4).
- R10: Opcodes 5 to 7 still produce `out_valid`, but with `dst_we`, `cf_upd` and `zf_upd` low and `result`, `cf` and `zf` held.
- R11: With `size32`=0, a modify operation returns `dst[31:16]` unchanged in `result[31:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0 scan, 1 test, 2 complement, 3 reset, 4 set) |
| size32 | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| src | input | 32 | Scan source word |
| dst | input | 32 | Destination word for test operations, and pass-through value |
| imm_sel | input | 1 | 1 = offset from `imm_off`, 0 = from `reg_off` |
| imm_off | input | 8 | Immediate bit offset |
| reg_off | input | 32 | Register bit offset |
| out_valid | output | 1 | Response strobe |
| result | output | 32 | Result word |
| dst_we | output | 1 | Destination write-enable |
| cf | output | 1 | Carry flag value |
| cf_upd | output | 1 | Carry flag update strobe |
| zf | output | 1 | Zero flag value |
| zf_upd | output | 1 | Zero flag update strobe |

## Verification
The hardest case to reach is a flag that must hold while unrelated traffic passes. The test family must leave `zf` at the value the last scan set. Offsets above the operand width must alias onto the right bit in 16-bit mode without touching the upper half. The stimulus therefore places scans and test operations back to back and between idle gaps. It uses offsets with high bits set from both offset sources, and 16-bit scans whose only set bits lie above bit 15. A behavioural model follows the held flag state and compares every output on every clock.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    typedef enum logic [2:0] {
        OP_SCAN = 3'd0,
        OP_TEST = 3'd1,
        OP_FLIP = 3'd2,
        OP_CLR  = 3'd3,
        OP_SET  = 3'd4
    } bop_e;

    typedef enum logic [1:0] {
        MOD_KEEP = 2'd0,
        MOD_FLIP = 2'd1,
        MOD_CLR  = 2'd2,
        MOD_SET  = 2'd3
    } bmod_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bst_e;
endpackage

// File: rtl/bitop_scan.sv
module bitop_scan #(
    parameter int W = 32,
    localparam int IDXW = $clog2(W)
) (
    input  logic [W-1:0]    vec,
    output logic [IDXW-1:0] idx,
    output logic            nz
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDXW'(i);
        end
        nz = |vec;
    end
endmodule

// File: rtl/bitop_bitsel.sv
module bitop_bitsel #(
    parameter int W = 32,
    localparam int IDXW = $clog2(W)
) (
    input  logic [W-1:0]    word,
    input  logic [IDXW-1:0] pos,
    input  bitop_pkg::bmod_e mode,
    output logic            old_bit,
    output logic [W-1:0]    new_word
);
    import bitop_pkg::*;

    logic [W-1:0] onehot;

    always_comb begin
        onehot  = '0;
        onehot[pos] = 1'b1;
        old_bit = word[pos];
        unique case (mode)
            MOD_FLIP: new_word = word ^ onehot;
            MOD_CLR:  new_word = word & ~onehot;
            MOD_SET:  new_word = word | onehot;
            default:  new_word = word;
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit #(
    parameter int W = 32,
    localparam int HALF = W / 2,
    localparam int IDXW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic          size32,
    input  logic [W-1:0]  src,
    input  logic [W-1:0]  dst,
    input  logic          imm_sel,
    input  logic [7:0]    imm_off,
    input  logic [W-1:0]  reg_off,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic          dst_we,
    output logic          cf,
    output logic          cf_upd,
    output logic          zf,
    output logic          zf_upd
);
    import bitop_pkg::*;

    bst_e            state_q;
    logic [W-1:0]    scan_vec;
    logic [IDXW-1:0] scan_idx;
    logic            scan_nz;
    logic [IDXW-1:0] off_lo;
    logic [IDXW-1:0] bit_pos;
    bmod_e           mod_sel;
    logic            sel_bit;
    logic [W-1:0]    mod_word;
    logic            unused_off_hi;

    logic [W-1:0]    nx_result;
    logic            nx_we, nx_cf, nx_cfu, nx_zf, nx_zfu;

    assign scan_vec = size32 ? src : {{HALF{1'b0}}, src[HALF-1:0]};
    assign off_lo   = imm_sel ? imm_off[IDXW-1:0] : reg_off[IDXW-1:0];
    assign bit_pos  = size32 ? off_lo : {1'b0, off_lo[IDXW-2:0]};
    assign unused_off_hi = ^{imm_off[7:IDXW], reg_off[W-1:IDXW]};

    always_comb begin
        unique case (op)
            OP_FLIP: mod_sel = MOD_FLIP;
            OP_CLR:  mod_sel = MOD_CLR;
            OP_SET:  mod_sel = MOD_SET;
            default: mod_sel = MOD_KEEP;
        endcase
    end

    bitop_scan #(.W(W)) u_scan (
        .vec (scan_vec),
        .idx (scan_idx),
        .nz  (scan_nz)
    );

    bitop_bitsel #(.W(W)) u_bitsel (
        .word     (dst),
        .pos      (bit_pos),
        .mode     (mod_sel),
        .old_bit  (sel_bit),
        .new_word (mod_word)
    );

    always_comb begin
        nx_result = result;
        nx_we     = 1'b0;
        nx_cf     = cf;
        nx_cfu    = 1'b0;
        nx_zf     = zf;
        nx_zfu    = 1'b0;
        unique case (op)
            OP_SCAN: begin
                nx_zfu = 1'b1;
                if (scan_nz) begin
                    nx_result = {{(W-IDXW){1'b0}}, scan_idx};
                    nx_we     = 1'b1;
                    nx_zf     = 1'b0;
                end else begin
                    nx_result = dst;
                    nx_zf     = 1'b1;
                end
            end
            OP_TEST: begin
                nx_result = dst;
                nx_cf     = sel_bit;
                nx_cfu    = 1'b1;
            end
            OP_FLIP, OP_CLR, OP_SET: begin
                nx_result = mod_word;
                nx_we     = 1'b1;
                nx_cf     = sel_bit;
                nx_cfu    = 1'b1;
            end
            default: ;
        endcase
    end

    // State register: accept moves to ST_RESP, drain returns to ST_IDLE
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= in_valid ? ST_RESP : ST_IDLE;
    end

    assign out_valid = (state_q == ST_RESP);

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            dst_we <= 1'b0;
            cf     <= 1'b0;
            cf_upd <= 1'b0;
            zf     <= 1'b0;
            zf_upd <= 1'b0;
        end else if (in_valid) begin
            result <= nx_result;
            dst_we <= nx_we;
            cf     <= nx_cf;
            cf_upd <= nx_cfu;
            zf     <= nx_zf;
            zf_upd <= nx_zfu;
        end else begin
            dst_we <= 1'b0;
            cf_upd <= 1'b0;
            zf_upd <= 1'b0;
        end
    end

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(result) && $stable(cf) && $stable(zf)));
    a_r2_strobes_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we || cf_upd || zf_upd) |-> out_valid);
    a_r3_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        scan_nz |-> (scan_vec[scan_idx] &&
                     ((scan_vec & ((W'(1) << scan_idx) - W'(1))) == '0)));
    a_r4_zero_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (zf_upd && zf) |-> !dst_we);
    a_r3_scan_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        zf_upd |-> !cf_upd);
    a_r9_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mod_word ^ dst) <= 1);
    a_r11_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !size32 |-> (mod_word[W-1:HALF] == dst[W-1:HALF]));
endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        size32 = 1'b1;
    logic [31:0] src = '0;
    logic [31:0] dst = '0;
    logic        imm_sel = 1'b0;
    logic [7:0]  imm_off = '0;
    logic [31:0] reg_off = '0;
    logic        out_valid, dst_we, cf, cf_upd, zf, zf_upd;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [31:0] m_result = '0;
    logic        m_cf = 1'b0, m_zf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit u_bitop_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size32(size32),
        .src(src), .dst(dst), .imm_sel(imm_sel), .imm_off(imm_off), .reg_off(reg_off),
        .out_valid(out_valid), .result(result), .dst_we(dst_we), .cf(cf),
        .cf_upd(cf_upd), .zf(zf), .zf_upd(zf_upd)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic compare(input string tag, input logic [37:0] exp);
        logic [37:0] act;
        act = {out_valid, dst_we, cf_upd, zf_upd, cf, zf, result};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual {ov,we,cfu,zfu,cf,zf,res}=%b_%h expected %b_%h",
                     tag, act[37:32], act[31:0], exp[37:32], exp[31:0]);
        end
    endtask

    // One clock: apply inputs after a falling edge, check at the next falling edge.
    task automatic step(input string tag, input logic v, input logic [2:0] o,
                        input logic s32, input logic [31:0] s, input logic [31:0] d,
                        input logic isel, input logic [7:0] imm, input logic [31:0] ro);
        logic e_we, e_cfu, e_zfu;
        int w, first, off, b;
        in_valid = v; op = o; size32 = s32; src = s; dst = d;
        imm_sel = isel; imm_off = imm; reg_off = ro;
        e_we = 0; e_cfu = 0; e_zfu = 0;
        if (v) begin
            w = s32 ? 32 : 16;
            off = isel ? int'(imm) : int'(ro & 32'h7fff_ffff);
            b = off % w;
            case (o)
                3'd0: begin
                    first = -1;
                    for (int i = 0; i < w; i++) if (s[i] && first < 0) first = i;
                    e_zfu = 1;
                    if (first >= 0) begin
                        m_result = 32'(first); e_we = 1; m_zf = 0;
                    end else begin
                        m_result = d; m_zf = 1;
                    end
                end
                3'd1: begin m_cf = d[b]; e_cfu = 1; m_result = d; end
                3'd2: begin m_cf = d[b]; e_cfu = 1; e_we = 1; m_result = d; m_result[b] = ~d[b]; end
                3'd3: begin m_cf = d[b]; e_cfu = 1; e_we = 1; m_result = d; m_result[b] = 1'b0; end
                3'd4: begin m_cf = d[b]; e_cfu = 1; e_we = 1; m_result = d; m_result[b] = 1'b1; end
                default: ;
            endcase
        end
        @(negedge clk);
        compare(tag, {v, e_we, e_cfu, e_zfu, m_cf, m_zf, m_result});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset", 38'd0);
        rst_n = 1'b1;
        step("R1 after reset idle", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R3 scan 01241240h -> 6", 1, 0, 1, 32'h0124_1240, 32'hAAAA_5555, 0, 0, 0);
        step("R2 idle hold", 0, 0, 1, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
        step("R3 scan msb only -> 31", 1, 0, 1, 32'h8000_0000, 0, 0, 0, 0);
        step("R4 scan zero keeps dst", 1, 0, 1, 32'h0, 32'hDEAD_BEEF, 0, 0, 0);
        step("R5 16-bit scan ignores upper half", 1, 0, 0, 32'h0001_0000, 32'h1234_5678, 0, 0, 0);
        step("R5 16-bit scan -> 15", 1, 0, 0, 32'h8000_8000, 0, 0, 0, 0);
        step("R6 scan ignores offset", 1, 0, 1, 32'h0000_0100, 0, 1, 8'd3, 32'd7);
        step("R8 test FFFF0080h off 2", 1, 1, 1, 0, 32'hFFFF_0080, 1, 8'd2, 0);
        step("R8 test 1234081Fh off 33", 1, 1, 1, 0, 32'h1234_081F, 1, 8'd33, 0);
        step("R7 reg offset 35 -> bit 3", 1, 1, 1, 0, 32'h0000_0008, 0, 8'd0, 32'd35);
        step("R7 16-bit offset 17 -> bit 1", 1, 1, 0, 0, 32'h0000_0002, 1, 8'd17, 0);
        step("R9 complement bit 4", 1, 2, 1, 0, 32'h0000_00F0, 1, 8'd4, 0);
        step("R9 reset bit 31", 1, 3, 1, 0, 32'hFFFF_FFFF, 0, 0, 32'd63);
        step("R9 set bit 0", 1, 4, 1, 0, 32'h0, 1, 8'd32, 0);
        step("R11 16-bit set keeps upper", 1, 4, 0, 0, 32'hA5A5_0000, 1, 8'd31, 0);
        step("R11 16-bit complement keeps upper", 1, 2, 0, 0, 32'hFFFF_FFFF, 0, 0, 32'hFFFF_FFF0);
        step("R10 opcode 5 no effect", 1, 5, 1, 32'hF, 32'h0, 1, 8'd1, 0);
        step("R10 opcode 7 no effect", 1, 7, 1, 32'hF, 32'h0, 1, 8'd1, 0);
        step("R2 idle after burst", 0, 2, 1, 32'hF, 32'h0, 1, 8'd1, 0);
        for (int n = 0; n < 400; n++) begin
            logic [31:0] rs, rd, rr;
            rs = $urandom;
            rd = $urandom;
            rr = $urandom;
            if (n % 3 == 0) rs = rs & (32'h1 << (n % 32));
            step("R2 R3 R7 R8 R9 mixed", ($urandom_range(0, 3) != 0), 3'($urandom_range(0, 5)),
                 1'($urandom_range(0, 1)), rs, rd, 1'($urandom_range(0, 1)),
                 8'($urandom), rr);
        end
        finish_run();
    end
endmodule